// File: doc/BRIEF.md
# Wrapper boundary register cell chain

This block is the boundary register that isolates an embedded core for test. It is built from one cell per functional core terminal, linked serially from a serial input to a serial output. Each cell sits between the terminal's functional source and its destination. It holds a shift/capture flop and a separate update flop that is loaded in the style of a JTAG update. A two-bit mode code chooses what the cell presents on its functional output: the functional input unchanged, the update value, or a fixed safe value.

At elaboration each cell is set as a core-input terminal (the cell drives into the core) or a core-output terminal (the cell drives toward the system). The inward-facing and outward-facing modes mirror each other. In inward mode the core-input cells apply their update value. In outward mode the core-output cells apply theirs. Cells that do not drive in the current mode pass their functional input through, and they still capture and shift. A transfer event copies the update flop back into the shift flop, so the applied pattern can be read out or reused. The serial interface layer supplies the shift, capture, update and transfer enables and the mode code. Instruction decoding happens outside this block.

Top module: `wbr_chain`

## Requirements
- R1: After reset, every shift flop and every update flop holds 0. `so` reads 0, and any cell that is driving presents 0.
- R2: With mode 2'b00 (normal), `func_out` equals `func_in` on every bit, combinationally.
- R3: When `shift_en` is high at a clock edge, cell 0 loads `si` and cell i loads the old value of cell i-1. `so` is the shift flop of cell N-1. Shift takes priority over capture and transfer.
- R4: When `capture_en` is high and `shift_en` is low, each shift flop loads its own `func_in` bit. Capture takes priority over transfer.
- R5: When `update_en` is high at a clock edge, each update flop loads the value its shift flop held before that edge. Shift flops are unaffected by update.
- R6: With mode 2'b01 (inward), a cell whose `DIR_MASK` bit is 1 (core-input terminal) drives its update value. A cell whose bit is 0 passes `func_in`.
- R7: With mode 2'b10 (outward), a cell whose `DIR_MASK` bit is 0 (core-output terminal) drives its update value. A cell whose bit is 1 passes `func_in`.
- R8: With mode 2'b11 (safe), `func_out` equals `SAFE_VAL` on every bit, whatever the inputs.
- R9: When `transfer_en` is high and both `shift_en` and `capture_en` are low, each shift flop loads its own update flop.
- R10: With no enable high, both flops of every cell hold their values. An update flop changes only when `update_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 normal, 01 inward, 10 outward, 11 safe |
| shift_en | input | 1 | Shift the chain one position |
| capture_en | input | 1 | Sample functional inputs into the shift flops |
| update_en | input | 1 | Load update flops from shift flops |
| transfer_en | input | 1 | Load shift flops from update flops |
| si | input | 1 | Serial test input to cell 0 |
| func_in | input | N | Functional inputs, one per cell |
| func_out | output | N | Functional outputs, one per cell |
| so | output | 1 | Serial test output from cell N-1 |

## Verification
The properties treat the enables as plain levels sampled at each edge. They allow any mix of enables in the same cycle, and they rely on the stated priority of shift over capture over transfer. The output properties are combinational and assume the mode code is stable while it is sampled. The stimulus changes enables, mode and functional inputs only just after a falling edge. It includes cycles where two enables are high at once, so that the priority rules and the update-during-shift ordering are both exercised.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_INWARD  = 2'b01,
    MODE_OUTWARD = 2'b10,
    MODE_SAFE    = 2'b11
  } wbr_mode_e;
endpackage

// File: rtl/wbr_rst_sync.sv
module wbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wbr_drive_sel.sv
module wbr_drive_sel
  import wbr_pkg::*;
#(
  parameter bit CORE_INPUT = 1'b1,
  parameter bit SAFE_BIT   = 1'b0
) (
  input  wbr_mode_e mode,
  input  logic      cfi,
  input  logic      upd,
  output logic      cfo
);
  // The driving mode of a cell depends on which side of the core it faces.
  localparam wbr_mode_e DRIVE_MODE = CORE_INPUT ? MODE_INWARD : MODE_OUTWARD;

  always_comb begin
    if (mode == MODE_SAFE)       cfo = SAFE_BIT;
    else if (mode == DRIVE_MODE) cfo = upd;
    else                         cfo = cfi;
  end
endmodule

// File: rtl/wbr_cell.sv
module wbr_cell
  import wbr_pkg::*;
#(
  parameter bit CORE_INPUT = 1'b1,
  parameter bit SAFE_BIT   = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      capture_en,
  input  logic      update_en,
  input  logic      transfer_en,
  input  wbr_mode_e mode,
  input  logic      cti,
  input  logic      cfi,
  output logic      cfo,
  output logic      cto,
  output logic      upd_q
);
  logic sh_q, sh_d, up_d;

  // Next state: shift wins over capture, capture over transfer.
  always_comb begin
    sh_d = sh_q;
    if (shift_en)         sh_d = cti;
    else if (capture_en)  sh_d = cfi;
    else if (transfer_en) sh_d = upd_q;
  end

  always_comb begin
    up_d = upd_q;
    if (update_en) up_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      upd_q <= up_d;
    end
  end

  assign cto = sh_q;

  wbr_drive_sel #(.CORE_INPUT(CORE_INPUT), .SAFE_BIT(SAFE_BIT)) i_sel (
    .mode (mode),
    .cfi  (cfi),
    .upd  (upd_q),
    .cfo  (cfo)
  );
endmodule

// File: rtl/wbr_chain.sv
module wbr_chain
  import wbr_pkg::*;
#(
  parameter int             N        = 8,
  parameter logic [N-1:0]   DIR_MASK = 8'h0F,
  parameter logic [N-1:0]   SAFE_VAL = 8'hA5,
  parameter int             RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         shift_en,
  input  logic         capture_en,
  input  logic         update_en,
  input  logic         transfer_en,
  input  logic         si,
  input  logic [N-1:0] func_in,
  output logic [N-1:0] func_out,
  output logic         so
);
  localparam int LAST = N - 1;

  logic         rst_sync_n;
  logic [N:0]   chain;
  logic [N-1:0] sh_vec;
  logic [N-1:0] up_vec;
  wbr_mode_e    mode_e;

  assign mode_e   = wbr_mode_e'(mode);
  assign chain[0] = si;

  wbr_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    wbr_cell #(.CORE_INPUT(DIR_MASK[i]), .SAFE_BIT(SAFE_VAL[i])) i_cell (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .shift_en    (shift_en),
      .capture_en  (capture_en),
      .update_en   (update_en),
      .transfer_en (transfer_en),
      .mode        (mode_e),
      .cti         (chain[i]),
      .cfi         (func_in[i]),
      .cfo         (func_out[i]),
      .cto         (chain[i+1]),
      .upd_q       (up_vec[i])
    );
    assign sh_vec[i] = chain[i+1];
  end

  assign so = chain[LAST+1];
endmodule

// File: rtl/wbr_chain_chk.sv
module wbr_chain_chk #(
  parameter int           N        = 8,
  parameter logic [N-1:0] DIR_MASK = 8'h0F,
  parameter logic [N-1:0] SAFE_VAL = 8'hA5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         shift_en,
  input logic         capture_en,
  input logic         update_en,
  input logic         transfer_en,
  input logic         si,
  input logic [N-1:0] func_in,
  input logic [N-1:0] func_out,
  input logic [N-1:0] sh_vec,
  input logic [N-1:0] up_vec
);
  p_normal_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> func_out == func_in);

  p_safe_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> func_out == SAFE_VAL);

  p_inward_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> func_out == ((up_vec & DIR_MASK) | (func_in & ~DIR_MASK)));

  p_outward_mix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> func_out == ((up_vec & ~DIR_MASK) | (func_in & DIR_MASK)));

  p_shift_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sh_vec[0] == $past(si));

  p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en && !shift_en |=> sh_vec == $past(func_in));

  p_update_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> up_vec == $past(sh_vec));

  p_transfer_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    transfer_en && !shift_en && !capture_en |=> sh_vec == $past(up_vec));

  p_upd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(up_vec));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en && !capture_en && !transfer_en |=> $stable(sh_vec));
endmodule

bind wbr_chain wbr_chain_chk #(.N(N), .DIR_MASK(DIR_MASK), .SAFE_VAL(SAFE_VAL)) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .mode        (mode),
  .shift_en    (shift_en),
  .capture_en  (capture_en),
  .update_en   (update_en),
  .transfer_en (transfer_en),
  .si          (si),
  .func_in     (func_in),
  .func_out    (func_out),
  .sh_vec      (sh_vec),
  .up_vec      (up_vec)
);

// File: tb/test_wbr_chain.sv
`timescale 1ns/1ps
module test_wbr_chain;
  localparam int           N    = 8;
  localparam logic [N-1:0] DIR  = 8'h0F;
  localparam logic [N-1:0] SAFE = 8'hA5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         shift_en, capture_en, update_en, transfer_en, si;
  logic [N-1:0] func_in, func_out;
  logic         so;

  always #2.5 clk = ~clk;

  wbr_chain #(.N(N), .DIR_MASK(DIR), .SAFE_VAL(SAFE)) i_wbr_chain (
    .clk(clk), .rst_n(rst_n), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .transfer_en(transfer_en),
    .si(si), .func_in(func_in), .func_out(func_out), .so(so)
  );

  typedef struct { int req; logic [N:0] exp; } item_t;
  item_t        q[$];
  int           compared = 0;
  int           mismatched = 0;
  bit           done = 0;
  logic [N-1:0] m_sh, m_up;

  function automatic logic [N-1:0] model_fo();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (mode)
        2'b00:   r[i] = func_in[i];
        2'b01:   r[i] = DIR[i] ? m_up[i] : func_in[i];
        2'b10:   r[i] = DIR[i] ? func_in[i] : m_up[i];
        default: r[i] = SAFE[i];
      endcase
    end
    return r;
  endfunction

  // Driver side of the scoreboard: push the expected output word.
  task automatic expect_now(int req);
    item_t it;
    it.req = req;
    it.exp = {m_sh[N-1], model_fo()};
    q.push_back(it);
    #1;
  endtask

  task automatic tick(bit sh, bit cap, bit upd, bit tr, bit s_in);
    logic [N-1:0] nsh, nup;
    shift_en = sh; capture_en = cap; update_en = upd; transfer_en = tr; si = s_in;
    for (int i = 0; i < N; i++) begin
      if (sh)       nsh[i] = (i == 0) ? s_in : m_sh[i-1];
      else if (cap) nsh[i] = func_in[i];
      else if (tr)  nsh[i] = m_up[i];
      else          nsh[i] = m_sh[i];
    end
    nup = upd ? m_sh : m_up;
    @(posedge clk);
    m_sh = nsh;
    m_up = nup;
    @(negedge clk);
    shift_en = 0; capture_en = 0; update_en = 0; transfer_en = 0; si = 0;
    #1;
  endtask

  // Monitor side: pop and compare against the ports.
  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      compared++;
      if ({so, func_out} !== it.exp) begin
        mismatched++;
        $display("FAIL R%0d: got so/func_out %b expected %b", it.req, {so, func_out}, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode = 2'b00; si = 0; func_in = 8'h5A;
    shift_en = 0; capture_en = 0; update_en = 0; transfer_en = 0;
    m_sh = '0; m_up = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, passthrough and zero drive
    expect_now(1);
    mode = 2'b01; #1; expect_now(1);
    // R2: normal passthrough under several patterns
    mode = 2'b00;
    func_in = 8'h00; #1; expect_now(2);
    func_in = 8'hFF; #1; expect_now(2);
    func_in = 8'h96; #1; expect_now(2);
    // R3: serial shift of 8'hC3, LSB first
    for (int b = 0; b < N; b++) begin
      tick(1, 0, 0, 0, 8'(8'hC3 >> b) & 1'b1);
      expect_now(3);
    end
    // R3: shift beats capture in the same cycle
    tick(1, 1, 0, 0, 1);
    expect_now(3);
    // R5: update loads the shift flops; shift flops untouched
    tick(0, 0, 1, 0, 0);
    expect_now(5);
    // R6: inward drive on core-input cells
    mode = 2'b01; #1; expect_now(6);
    func_in = 8'h33; #1; expect_now(6);
    // R7: outward drive on core-output cells
    mode = 2'b10; #1; expect_now(7);
    func_in = 8'hCC; #1; expect_now(7);
    // R8: safe value regardless of inputs
    mode = 2'b11; #1; expect_now(8);
    func_in = 8'h0F; #1; expect_now(8);
    // R4: capture then shift out
    mode = 2'b00; func_in = 8'h6D; #1;
    tick(0, 1, 0, 0, 0);
    expect_now(4);
    for (int b = 0; b < N - 1; b++) begin
      tick(1, 0, 0, 0, 0);
      expect_now(4);
    end
    // R4: capture beats transfer
    func_in = 8'hB2; #1;
    tick(0, 1, 0, 1, 0);
    expect_now(4);
    // R10: idle cycles hold both flops; update value survived capture/shift
    tick(0, 0, 0, 0, 1);
    expect_now(10);
    tick(0, 0, 0, 0, 0);
    mode = 2'b01; #1; expect_now(10);
    // R9: transfer copies update flops back, then read out
    mode = 2'b00; #1;
    tick(0, 0, 0, 1, 0);
    expect_now(9);
    for (int b = 0; b < N - 1; b++) begin
      tick(1, 0, 0, 0, 1);
      expect_now(9);
    end
    // R5: update together with shift takes the pre-shift value
    tick(1, 0, 1, 0, 0);
    mode = 2'b10; #1; expect_now(5);
    wait (q.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule